// File: doc/BRIEF.md
# Fractional clock divider with LFSR-coded coarse count

This block derives a slower clock from its input clock at a ratio that need not be an integer. Each half-period of the output lasts a base number of input cycles, and a phase accumulator decides, one half-period at a time, whether to add one extra input cycle. Over many half-periods the average ratio reaches a fine fractional target. The extended and plain half-periods are spread out rather than grouped together.

The base count is not kept in a binary counter. It runs in a maximal-length Galois LFSR, which is short and fast. Software therefore programs the coarse divisor as an LFSR state rather than as a number. The code for a count n is the state the register reaches after n steps from the seed. A count of zero is special and is written as code zero. The block adds a fixed offset to the decoded count. A small register port holds five values: the enable, the coarse code, two accumulator increments and an accumulator start value. Values written while the block runs take effect at the next half-period boundary.

The block drives a divided clock with a duty cycle near 50%. It also drives a one-cycle strobe that marks each rising edge of that clock, for logic that prefers clock enables.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, `clk_out` and `edge_stb` are low and the registers read back as follows: control 0, code 0, both increments 0, seed 0x8000_0000.
- R2: The register addresses are 0 control, 1 code, 2 increment A, 3 increment B and 4 seed. A read of address `cfg_raddr` returns the value last written there. Control keeps only bit 0 (the enable) and the code register keeps only its low CODE_W bits (default 11). All other bits read as 0, and unused addresses read 0.
- R3: With code register value C, each half-period lasts n + OFFSET + e input cycles, where OFFSET defaults to 2 and e is the extension bit from R4. The count n is defined by C as follows. C = 0 means n = 0. Otherwise C is the state reached after n steps from seed 1 of a right-shifting Galois LFSR with mask TAPS (default 0x500). One step is: if bit 0 is set, shift right and XOR 0x500; otherwise just shift right.
- R4: The extension bit e of a half-period is bit 31 of the 32-bit accumulator during that half-period. At the end of the half-period the accumulator adds increment B if e = 1 and increment A if e = 0, wrapping modulo 2^32.
- R5: When the block is enabled, the accumulator starts from the seed register. A seed written while the block runs replaces the accumulator at the end of the current half-period, and the sum for that half-period is discarded.
- R6: A code or increment written while the block runs does not affect the current half-period. It applies from the next half-period. The increment used at the end of each half-period is the one that was in force during that half-period.
- R7: While the enable is 0, `clk_out` and `edge_stb` are low from the second cycle after the enable is cleared. Enabling again restarts with a low half-period of full length.
- R8: `clk_out` toggles at the end of every half-period. The first rising edge comes L input cycles after the clock edge that captures the enable, where L is the length of the first half-period.
- R9: `edge_stb` is high for exactly the cycle in which `clk_out` has just risen, and it is low on every falling edge.
- R10: While the block runs, the LFSR state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| clk_out | output | 1 | Divided clock |
| edge_stb | output | 1 | One-cycle pulse on each rising edge of clk_out |

## Verification
The assertions assume three things. The code register holds zero or a state on the LFSR cycle. A running half-period is never shorter than OFFSET cycles. No seed write lands in the same cycle as a half-period boundary. The stimulus keeps to these by computing every code with the bench's own stepping of the stated polynomial. It also issues every write in the cycle just after a toggle has been seen, and with the default offset every half-period is at least two cycles, so writes never reach a boundary cycle. Expected half-period lengths come from an arithmetic model of the accumulator that runs alongside the design.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   localparam int unsigned CFG_AW = 3;

   typedef enum logic [CFG_AW-1:0] {
      SEL_CTRL   = 3'd0,
      SEL_CODE   = 3'd1,
      SEL_STEP_A = 3'd2,
      SEL_STEP_B = 3'd3,
      SEL_SEED   = 3'd4
   } cfg_sel_e;

   // width of a counter that must hold the values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
   import fcd_pkg::*;
#(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned CODE_W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CFG_AW-1:0]   waddr,
   input  logic [ACC_W-1:0]    wdata,
   input  logic [CFG_AW-1:0]   raddr,
   output logic [ACC_W-1:0]    rdata,
   output logic                run,
   output logic [CODE_W-1:0]   code,
   output logic [ACC_W-1:0]    step_a,
   output logic [ACC_W-1:0]    step_b,
   output logic [ACC_W-1:0]    seed,
   output logic                seed_wr
);
   localparam logic [ACC_W-1:0] SEED_RST = {1'b1, {(ACC_W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         code   <= '0;
         step_a <= '0;
         step_b <= '0;
         seed   <= SEED_RST;
      end else if (we) begin
         case (cfg_sel_e'(waddr))
            SEL_CTRL:   run    <= wdata[0];
            SEL_CODE:   code   <= wdata[CODE_W-1:0];
            SEL_STEP_A: step_a <= wdata;
            SEL_STEP_B: step_b <= wdata;
            SEL_SEED:   seed   <= wdata;
            default: ;
         endcase
      end
   end

   assign seed_wr = we && (cfg_sel_e'(waddr) == SEL_SEED);

   always_comb begin
      case (cfg_sel_e'(raddr))
         SEL_CTRL:   rdata = ACC_W'(run);
         SEL_CODE:   rdata = ACC_W'(code);
         SEL_STEP_A: rdata = step_a;
         SEL_STEP_B: rdata = step_b;
         SEL_SEED:   rdata = seed;
         default:    rdata = '0;
      endcase
   end

   // R1: the seed register is at its reset value on the first cycle after reset
   p_seed_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> seed == SEED_RST);
endmodule

// File: rtl/fcd_lfsr_count.sv
module fcd_lfsr_count
   import fcd_pkg::*;
#(
   parameter int unsigned       CODE_W = 11,
   parameter logic [CODE_W-1:0] TAPS   = 11'h500,
   parameter logic [CODE_W-1:0] SEED   = 11'h001,
   parameter int unsigned       OFFSET = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] term,
   input  logic              ext,
   output logic              bnd
);
   localparam int unsigned TAIL_W = cnt_width(OFFSET);

   logic [CODE_W-1:0] state_q, state_nxt;
   logic [TAIL_W-1:0] tail_q, tail_lim;
   logic              term_hit;

   // Galois step, right-shifting form
   always_comb begin
      state_nxt = state_q >> 1;
      if (state_q[0]) state_nxt = state_nxt ^ TAPS;
   end

   // code zero stands for a coarse count of zero: the state never reaches it
   assign term_hit = (term == '0) || (state_q == term);
   assign tail_lim = TAIL_W'(OFFSET - 1) + TAIL_W'(ext);
   assign bnd      = run && term_hit && (tail_q == tail_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
         tail_q  <= '0;
      end else if (!run || bnd) begin
         state_q <= SEED;
         tail_q  <= '0;
      end else if (!term_hit) begin
         state_q <= state_nxt;
      end else begin
         tail_q  <= tail_q + 1'b1;
      end
   end

   // R10: a maximal-length Galois register never falls into the all-zero state
   p_state_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0);
   // R3: the fixed tail never runs past offset plus one extension cycle
   p_tail_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) tail_q <= TAIL_W'(OFFSET));
   // R3: while the coarse count runs, the tail stays at zero
   p_tail_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) !term_hit |-> tail_q == '0);
endmodule

// File: rtl/fcd_phase_acc.sv
module fcd_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             bnd,
   input  logic [ACC_W-1:0] step_a,
   input  logic [ACC_W-1:0] step_b,
   input  logic [ACC_W-1:0] seed,
   input  logic             seed_wr,
   output logic             ext
);
   logic [ACC_W-1:0] acc_q, inc;
   logic             pend_q;

   assign ext = acc_q[ACC_W-1];
   assign inc = ext ? step_b : step_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         pend_q <= 1'b0;
      end else if (!run) begin
         acc_q  <= seed;
         pend_q <= 1'b0;
      end else if (bnd) begin
         acc_q  <= pend_q ? seed : acc_q + inc;
         pend_q <= seed_wr;
      end else begin
         pend_q <= pend_q | seed_wr;
      end
   end

   // R4: the accumulator moves only at a half-period boundary while running
   p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !bnd) |=> $stable(acc_q));
   // R4: without a pending seed, the boundary adds the increment picked by the MSB
   p_acc_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && !pend_q) |=> acc_q == $past(acc_q) + ($past(acc_q[ACC_W-1]) ? $past(step_b) : $past(step_a)));
   // R5: a pending seed replaces the sum at the boundary
   p_acc_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && pend_q) |=> acc_q == $past(seed));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import fcd_pkg::*;
#(
   parameter int unsigned       ACC_W    = 32,
   parameter int unsigned       CODE_W   = 11,
   parameter logic [CODE_W-1:0] TAPS     = 11'h500,
   parameter logic [CODE_W-1:0] SEED     = 11'h001,
   parameter int unsigned       OFFSET   = 2,
   parameter bit                STB_BOTH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_waddr,
   input  logic [ACC_W-1:0]  cfg_wdata,
   input  logic [CFG_AW-1:0] cfg_raddr,
   output logic [ACC_W-1:0]  cfg_rdata,
   output logic              clk_out,
   output logic              edge_stb
);
   // elaboration-time parameter checks
   if (CODE_W < 3 || CODE_W > 24) begin : g_bad_code_w
      $error("CODE_W must lie in 3..24");
   end
   if (ACC_W < 8 || ACC_W <= CODE_W) begin : g_bad_acc_w
      $error("ACC_W must be at least 8 and wider than CODE_W");
   end
   if (OFFSET < 1) begin : g_bad_offset
      $error("OFFSET must be at least 1");
   end
   if (!TAPS[CODE_W-1] || SEED == '0) begin : g_bad_lfsr
      $error("TAPS needs its top bit set and SEED must be nonzero");
   end

   logic              run, seed_wr, bnd, ext;
   logic [CODE_W-1:0] code, act_code;
   logic [ACC_W-1:0]  step_a, step_b, seed, act_a, act_b;
   logic              clk_q, stb_q;

   fcd_regs #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
      .raddr(cfg_raddr), .rdata(cfg_rdata), .run(run), .code(code),
      .step_a(step_a), .step_b(step_b), .seed(seed), .seed_wr(seed_wr)
   );

   // shadow copies: programmed values are adopted only at a boundary or while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_code <= '0;
         act_a    <= '0;
         act_b    <= '0;
      end else if (!run || bnd) begin
         act_code <= code;
         act_a    <= step_a;
         act_b    <= step_b;
      end
   end

   fcd_lfsr_count #(.CODE_W(CODE_W), .TAPS(TAPS), .SEED(SEED), .OFFSET(OFFSET)) u_count (
      .clk(clk), .rst_n(rst_n), .run(run), .term(act_code), .ext(ext), .bnd(bnd)
   );

   fcd_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .run(run), .bnd(bnd), .step_a(act_a), .step_b(act_b),
      .seed(seed), .seed_wr(seed_wr), .ext(ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     clk_q <= 1'b0;
      else if (!run)  clk_q <= 1'b0;
      else if (bnd)   clk_q <= ~clk_q;
   end

   if (STB_BOTH) begin : g_stb_both
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stb_q <= 1'b0;
         else        stb_q <= bnd;
      end
      // R9 (variant): a strobe accompanies every output transition
      p_stb_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
         stb_q |-> clk_q != $past(clk_q));
   end else begin : g_stb_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stb_q <= 1'b0;
         else        stb_q <= bnd && !clk_q;
      end
      // R9: the strobe marks exactly the rising edges of the divided clock
      p_stb_rise_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(clk_q) |-> stb_q);
      p_stb_only_r9: assert property (@(posedge clk) disable iff (!rst_n) stb_q |-> $rose(clk_q));
   end

   assign clk_out  = clk_q;
   assign edge_stb = stb_q;

   // R7: once disabled, the output and strobe are held low
   p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!clk_q && !stb_q));
   // R8: the divided clock changes only at boundaries, and always does there
   p_toggle_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !bnd) |=> $stable(clk_q));
   p_toggle_at_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> clk_q != $past(clk_q));
   // R6: shadow values stay fixed inside a running half-period
   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !bnd) |=> $stable(act_code) && $stable(act_a) && $stable(act_b));
endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [2:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic        clk_out, edge_stb;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_tog = 0;
   logic lvl = 1'b0;

   // model state
   logic [31:0] m_acc, m_a, m_b;
   int          m_n;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   frac_clk_div uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .clk_out(clk_out), .edge_stb(edge_stb)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [10:0] code_of(input int n);
      logic [10:0] s = 11'd1;
      for (int i = 0; i < n; i++) s = s[0] ? ((s >> 1) ^ 11'h500) : (s >> 1);
      return (n == 0) ? 11'd0 : s;
   endfunction

   // called at a negedge; write captured on the next posedge; returns at the following negedge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
      cfg_raddr = a;
      #1;
      chk(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   // wait for the next toggle and compare its spacing with the model
   task automatic period(input string req);
      int len;
      int exp_len;
      exp_len = m_n + 2 + int'(m_acc[31]);
      do @(negedge clk); while (clk_out == lvl && (cyc - last_tog) < 5000);
      len = cyc - last_tog;
      last_tog = cyc;
      chk(len == exp_len, req, len, exp_len);
      chk(clk_out == ~lvl, "R8 toggle", clk_out, ~lvl);
      chk(edge_stb == ~lvl, "R9 strobe", edge_stb, ~lvl);
      lvl = clk_out;
      m_acc = m_acc + (m_acc[31] ? m_b : m_a);
   endtask

   task automatic start(input int n, input logic [31:0] a, input logic [31:0] b, input logic [31:0] s);
      @(negedge clk);
      wr(3'd0, 32'd0);
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk(clk_out == 1'b0 && edge_stb == 1'b0, "R7 idle low", {clk_out, edge_stb}, 0);
         @(negedge clk);
      end
      wr(3'd1, {21'd0, code_of(n)});
      wr(3'd2, a);
      wr(3'd3, b);
      wr(3'd4, s);
      wr(3'd0, 32'd1);
      last_tog = cyc; lvl = 1'b0;
      m_n = n; m_a = a; m_b = b; m_acc = s;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
      chk(edge_stb == 1'b0, "R1 edge_stb", edge_stb, 0);
      rd_chk(3'd0, 32'd0, "R1 ctrl");
      rd_chk(3'd1, 32'd0, "R1 code");
      rd_chk(3'd2, 32'd0, "R1 step A");
      rd_chk(3'd3, 32'd0, "R1 step B");
      rd_chk(3'd4, 32'h8000_0000, "R1 seed");

      // R2 readback and field masking
      @(negedge clk);
      wr(3'd0, 32'hFFFF_FFFE);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, 32'h1234_5678);
      wr(3'd3, 32'h9ABC_DEF0);
      wr(3'd4, 32'h0F0F_1234);
      wr(3'd6, 32'hFFFF_FFFF);
      rd_chk(3'd0, 32'd0, "R2 ctrl masked");
      rd_chk(3'd1, 32'h0000_07FF, "R2 code masked");
      rd_chk(3'd2, 32'h1234_5678, "R2 step A");
      rd_chk(3'd3, 32'h9ABC_DEF0, "R2 step B");
      rd_chk(3'd4, 32'h0F0F_1234, "R2 seed");
      rd_chk(3'd6, 32'd0, "R2 unused address");
      chk(clk_out == 1'b0, "R7 no run while disabled", clk_out, 0);

      // R3/R4/R8 sweep of coarse counts with dithering increments
      for (int n = 0; n < 25; n++) begin
         logic [31:0] a;
         a = 32'h3000_0000 + 32'(n) * 32'h0123_4567;
         start(n, a, a - 32'h9000_0000, (n % 2 == 1) ? 32'h8000_0000 : 32'h0);
         rd_chk(3'd0, 32'd1, "R2 enable readback");
         for (int k = 0; k < 6; k++) period("R3 half-period length");
      end

      // R3 largest coarse count
      start(2046, 32'h8000_0000, 32'h8000_0000, 32'h0);
      for (int k = 0; k < 3; k++) period("R3 max count");

      // R6 code change mid-period
      start(5, 32'h4000_0000, 32'hC000_0000, 32'h8000_0000);
      period("R6 before change");
      wr(3'd1, {21'd0, code_of(9)});
      period("R6 old code in flight");
      m_n = 9;
      period("R6 new code");
      period("R6 new code");

      // R6 increment change mid-period
      wr(3'd2, 32'h7000_0000);
      period("R6 old step in flight");
      m_a = 32'h7000_0000;
      for (int k = 0; k < 4; k++) period("R6 new step");

      // R5 seed replacement while running
      wr(3'd4, 32'h8000_0000);
      period("R5 seed pending");
      m_acc = 32'h8000_0000;
      for (int k = 0; k < 4; k++) period("R5 after seed");

      // R7 disable mid-period, then restart
      if (clk_out == 1'b0) period("R7 reach high");
      wr(3'd0, 32'd0);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         chk(clk_out == 1'b0, "R7 forced low", clk_out, 0);
         chk(edge_stb == 1'b0, "R7 strobe low", edge_stb, 0);
         @(negedge clk);
      end
      start(3, 32'h6000_0000, 32'hA000_0000, 32'h8000_0000);
      for (int k = 0; k < 4; k++) period("R7 restart full length");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule